// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a bank of general-purpose I/O lines behind a simple register bus. The bus has an address, a write strobe, a read strobe, write data and read data. The block holds up to five registers of the same width: data, set, clear, direction-out and direction-in. Bit n of each register belongs to line n. Build-time parameters decide which registers exist, the register width, how many of the low lines are usable, whether the lines may be driven at all, and whether bus data is byte-swapped.

Which registers are present changes how writes behave. With no set register, a write to the data register loads the output values. With both set and clear, the two act as bit-wise set and clear strobes. With set but no clear, the set register loads the whole output word. Input pins pass through a two-flop synchroniser before they reach the read path.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: After a synchronous reset, every output value is 0, bus read data is 0, and every line is an input when a direction register exists.
- R2: Register addresses are 0 data, 1 set, 2 clear, 3 direction-out, 4 direction-in. Read data is valid in the cycle after a read strobe and is 0 otherwise. A data read returns, for each usable line, the driven value when the line is an output and the synchronised pin level when it is an input.
- R3: When the set register is absent, a write to the data register loads the output values.
- R4: With both set and clear present, a 1 in the set word drives that line high and a 1 in the clear word drives it low. Bits written as 0 leave their lines unchanged, and data-register writes do not alter the outputs. The set address reads back the output values, and the clear address reads back their complement over the usable lines.
- R5: With set present and clear absent, a set write loads the full output word, so a 0 bit drives its line low.
- R6: A 1 in the direction-out register makes a line an output and a 0 makes it an input. The register reads back what was stored.
- R7: A 1 in the direction-in register makes a line an input and a 0 makes it an output. This address reads back the complement of the output-enable state over the usable lines.
- R8: With neither direction register present, every usable line is an output at all times.
- R9: Lines at or above the usable-line count never drive, never enable, and read as 0.
- R10: In no-output mode, every output enable stays 0 whatever is written.
- R11: With big-endian order, byte k of the bus word maps to byte (W/8-1-k) of the register, on both writes and reads.
- R12: An address that is unmapped or whose register is absent reads as 0, and writes to it are ignored.
- R13: Output values and enables change only on a write that hits a present register. Reads leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | REG_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | REG_W | Read data, one cycle after the strobe |
| pin_in | input | REG_W | Asynchronous pin levels |
| pin_out | output | REG_W | Driven output values |
| pin_oe | output | REG_W | Output enables |

## Verification
The bench builds three instances side by side on one shared bus. The first is 16 bits wide with 12 usable lines and all five registers, which covers set/clear strobes, both direction polarities and line masking. The second is 16 bits wide with only the data register, no-output mode and big-endian order, which covers direct data writes, byte swapping in both directions and disabled enables. The third is 8 bits wide with set but no clear and no direction register, which covers whole-word set writes and lines that are always outputs. Single-bit sweeps and an arithmetic pattern loop over all eight addresses check every instance after each access against a model kept in the bench.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;
  localparam int unsigned ADDR_W = 3;

  // register addresses; software decodes these, so they are fixed
  localparam logic [ADDR_W-1:0] RS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] RS_SET  = 3'd1;
  localparam logic [ADDR_W-1:0] RS_CLR  = 3'd2;
  localparam logic [ADDR_W-1:0] RS_DOUT = 3'd3;
  localparam logic [ADDR_W-1:0] RS_DIN  = 3'd4;
  localparam logic [ADDR_W-1:0] RS_LAST = RS_DIN;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      sync_o <= '0;
    end else begin
      stage1 <= pin_i;
      sync_o <= stage1;
    end
  end
endmodule

// File: rtl/gpio_byte_order.sv
module gpio_byte_order #(
  parameter int unsigned W    = 32,
  parameter bit          SWAP = 1'b0
) (
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned NB = W / 8;

  generate
    if (SWAP && (W % 8 == 0)) begin : g_swap
      for (genvar b = 0; b < NB; b++) begin : g_byte
        assign q[8*b +: 8] = d[8*(NB-1-b) +: 8];
      end
    end else begin : g_pass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/gpio_reg_core.sv
module gpio_reg_core
  import gpio_mmio_pkg::*;
#(
  parameter int unsigned W         = 32,
  parameter int unsigned LINES     = 32,
  parameter bit          HAS_SET   = 1'b1,
  parameter bit          HAS_CLR   = 1'b1,
  parameter bit          HAS_DOUT  = 1'b1,
  parameter bit          HAS_DIN   = 1'b1,
  parameter bit          NO_OUTPUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      line_mask,
  output logic [W-1:0]      out_val,
  output logic [W-1:0]      dir_val,
  output logic [W-1:0]      oe_val
);
  localparam int unsigned USE_LINES = (LINES > W) ? W : LINES;

  // usable-line mask, one bit per line
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign line_mask[i] = (i < USE_LINES);
  end

  logic hit_data, hit_set, hit_clr, hit_dout, hit_din;
  assign hit_data = wr_en && (addr == RS_DATA);
  assign hit_set  = wr_en && (addr == RS_SET);
  assign hit_clr  = wr_en && (addr == RS_CLR);
  assign hit_dout = wr_en && (addr == RS_DOUT);
  assign hit_din  = wr_en && (addr == RS_DIN);

  logic [W-1:0] out_nxt;

  always_comb begin
    out_nxt = out_val;
    if (!HAS_SET && hit_data) out_nxt = wdata;
    if (HAS_SET && hit_set)   out_nxt = HAS_CLR ? (out_val | wdata) : wdata;
    if (HAS_CLR && hit_clr)   out_nxt = out_val & ~wdata;
    out_nxt = out_nxt & line_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) out_val <= '0;
    else     out_val <= out_nxt;
  end

  generate
    if (HAS_DOUT || HAS_DIN) begin : g_dir
      logic [W-1:0] dir_q, dir_nxt;
      always_comb begin
        dir_nxt = dir_q;
        if (HAS_DOUT && hit_dout) dir_nxt = wdata;
        if (HAS_DIN && hit_din)   dir_nxt = ~wdata;
        dir_nxt = dir_nxt & line_mask;
      end
      always_ff @(posedge clk) begin
        if (rst) dir_q <= '0;
        else     dir_q <= dir_nxt;
      end
      assign dir_val = dir_q;
    end else begin : g_fixed_dir
      assign dir_val = line_mask;
    end

    if (NO_OUTPUT) begin : g_no_drive
      assign oe_val = '0;
    end else begin : g_drive
      assign oe_val = dir_val;
    end
  endgenerate
endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path
  import gpio_mmio_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter bit          HAS_SET  = 1'b1,
  parameter bit          HAS_CLR  = 1'b1,
  parameter bit          HAS_DOUT = 1'b1,
  parameter bit          HAS_DIN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      line_mask,
  input  logic [W-1:0]      out_val,
  input  logic [W-1:0]      dir_val,
  input  logic [W-1:0]      oe_val,
  input  logic [W-1:0]      pin_sync,
  output logic [W-1:0]      rdata_q
);
  logic [W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    case (addr)
      RS_DATA: rd_nxt = ((oe_val & out_val) | (~oe_val & pin_sync)) & line_mask;
      RS_SET:  if (HAS_SET)  rd_nxt = out_val;
      RS_CLR:  if (HAS_CLR)  rd_nxt = ~out_val & line_mask;
      RS_DOUT: if (HAS_DOUT) rd_nxt = dir_val;
      RS_DIN:  if (HAS_DIN)  rd_nxt = ~dir_val & line_mask;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_nxt;
    else            rdata_q <= '0;
  end
endmodule

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl
  import gpio_mmio_pkg::*;
#(
  parameter int unsigned REG_W      = 32,
  parameter int unsigned LINES      = 32,
  parameter bit          HAS_SET    = 1'b1,
  parameter bit          HAS_CLR    = 1'b1,
  parameter bit          HAS_DOUT   = 1'b1,
  parameter bit          HAS_DIN    = 1'b1,
  parameter bit          NO_OUTPUT  = 1'b0,
  parameter bit          BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  pin_in,
  output logic [REG_W-1:0]  pin_out,
  output logic [REG_W-1:0]  pin_oe
);
  logic [REG_W-1:0] wr_native, rd_native, pin_sync;
  logic [REG_W-1:0] line_mask, out_val, dir_val, oe_val;

  gpio_byte_order #(.W(REG_W), .SWAP(BIG_ENDIAN)) u_wr_order (
    .d(bus_wdata), .q(wr_native)
  );

  gpio_in_sync #(.W(REG_W)) u_in_sync (
    .clk(clk), .rst(rst), .pin_i(pin_in), .sync_o(pin_sync)
  );

  gpio_reg_core #(
    .W(REG_W), .LINES(LINES), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR),
    .HAS_DOUT(HAS_DOUT), .HAS_DIN(HAS_DIN), .NO_OUTPUT(NO_OUTPUT)
  ) u_core (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(wr_native),
    .line_mask(line_mask), .out_val(out_val), .dir_val(dir_val), .oe_val(oe_val)
  );

  gpio_read_path #(
    .W(REG_W), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR),
    .HAS_DOUT(HAS_DOUT), .HAS_DIN(HAS_DIN)
  ) u_read (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .addr(bus_addr),
    .line_mask(line_mask), .out_val(out_val), .dir_val(dir_val),
    .oe_val(oe_val), .pin_sync(pin_sync), .rdata_q(rd_native)
  );

  gpio_byte_order #(.W(REG_W), .SWAP(BIG_ENDIAN)) u_rd_order (
    .d(rd_native), .q(bus_rdata)
  );

  assign pin_out = out_val;
  assign pin_oe  = oe_val;
endmodule

// File: rtl/gpio_ctrl_checker.sv
module gpio_ctrl_checker #(
  parameter int unsigned W          = 32,
  parameter int unsigned LINES      = 32,
  parameter bit          HAS_SET    = 1'b1,
  parameter bit          HAS_CLR    = 1'b1,
  parameter bit          HAS_DOUT   = 1'b1,
  parameter bit          NO_OUTPUT  = 1'b0,
  parameter bit          BIG_ENDIAN = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   bus_addr,
  input logic         bus_wr,
  input logic [W-1:0] bus_wdata,
  input logic         bus_rd,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe
);
  function automatic logic [W-1:0] usable_bits();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i < LINES);
    return r;
  endfunction
  localparam logic [W-1:0] MASK = usable_bits();

  assert_mask_R9: assert property (@(posedge clk) disable iff (rst)
    ((pin_out & ~MASK) == '0) && ((pin_oe & ~MASK) == '0));

  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  assert_unmapped_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr > 3'd4)) |=> (bus_rdata == '0));

  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));

  generate
    if (NO_OUTPUT) begin : g_no_out
      assert_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
        pin_oe == '0);
    end
    if (!BIG_ENDIAN && HAS_SET && HAS_CLR) begin : g_setclr
      assert_set_high_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd1) |=>
          ((pin_out & $past(bus_wdata) & MASK) == ($past(bus_wdata) & MASK)));
      assert_clr_low_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd2) |=> ((pin_out & $past(bus_wdata)) == '0));
    end
    if (!BIG_ENDIAN && !HAS_SET) begin : g_direct
      assert_data_load_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0) |=> (pin_out == ($past(bus_wdata) & MASK)));
    end
    if (!BIG_ENDIAN && HAS_DOUT && !NO_OUTPUT) begin : g_dout
      assert_dirout_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd3) |=> (pin_oe == ($past(bus_wdata) & MASK)));
    end
  endgenerate
endmodule

bind mmio_gpio_ctrl gpio_ctrl_checker #(
  .W(REG_W), .LINES(LINES), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR),
  .HAS_DOUT(HAS_DOUT), .NO_OUTPUT(NO_OUTPUT), .BIG_ENDIAN(BIG_ENDIAN)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/mmio_gpio_ctrl_bench.sv
module mmio_gpio_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MA = 16'h0FFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, pins = '0;
  logic [15:0] rdA, outA, oeA, rdB, outB, oeB;
  logic [7:0]  rdC, outC, oeC;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] eA_out = '0, eA_dir = '0, eB_out = '0;
  logic [7:0]  eC_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // full set of registers, 12 of 16 lines usable
  mmio_gpio_ctrl #(.REG_W(16), .LINES(12)) u_mmio_gpio_ctrl (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdA), .pin_in(pins), .pin_out(outA), .pin_oe(oeA));

  // data register only, no-output mode, big-endian
  mmio_gpio_ctrl #(.REG_W(16), .LINES(16), .HAS_SET(1'b0), .HAS_CLR(1'b0),
    .HAS_DOUT(1'b0), .HAS_DIN(1'b0), .NO_OUTPUT(1'b1), .BIG_ENDIAN(1'b1)) u_mmio_gpio_ctrl_be (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdB), .pin_in(pins), .pin_out(outB), .pin_oe(oeB));

  // set without clear, no direction register
  mmio_gpio_ctrl #(.REG_W(8), .LINES(8), .HAS_SET(1'b1), .HAS_CLR(1'b0),
    .HAS_DOUT(1'b0), .HAS_DIN(1'b0)) u_mmio_gpio_ctrl_set (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata[7:0]),
    .bus_rd(rd), .bus_rdata(rdC), .pin_in(pins[7:0]), .pin_out(outC), .pin_oe(oeC));

  function automatic logic [15:0] bsw(input logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pins(input string ctx);
    check({ctx, " R4 A out"}, outA, eA_out);
    check({ctx, " R6 R7 A oe"}, oeA, eA_dir);
    check({ctx, " R9 A upper"}, (outA | oeA) & ~MA, 16'h0);
    check({ctx, " R3 R11 B out"}, outB, eB_out);
    check({ctx, " R10 B oe"}, oeB, 16'h0);
    check({ctx, " R5 C out"}, {8'h0, outC}, {8'h0, eC_out});
    check({ctx, " R8 C oe"}, {8'h0, oeC}, 16'h00FF);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    case (a)
      3'd1: eA_out = (eA_out | d) & MA;
      3'd2: eA_out = eA_out & ~d;
      3'd3: eA_dir = d & MA;
      3'd4: eA_dir = ~d & MA;
      default: ;
    endcase
    if (a == 3'd0) eB_out = bsw(d);
    if (a == 3'd1) eC_out = d[7:0];
    check_pins("write");
  endtask

  task automatic do_read(input logic [2:0] a);
    logic [15:0] xa, xb;
    logic [7:0]  xc;
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    case (a)
      3'd0: xa = ((eA_dir & eA_out) | (~eA_dir & pins)) & MA;
      3'd1: xa = eA_out;
      3'd2: xa = ~eA_out & MA;
      3'd3: xa = eA_dir;
      3'd4: xa = ~eA_dir & MA;
      default: xa = 16'h0;
    endcase
    xb = (a == 3'd0) ? bsw(pins) : 16'h0;
    xc = (a == 3'd0 || a == 3'd1) ? eC_out : 8'h0;
    if (a == 3'd0)      check("R2 A data read", rdA, xa);
    else if (a <= 3'd2) check("R4 A set/clr read", rdA, xa);
    else if (a == 3'd3) check("R6 A dirout read", rdA, xa);
    else if (a == 3'd4) check("R7 A dirin read", rdA, xa);
    else                check("R12 A unmapped read", rdA, xa);
    if (a == 3'd0) check("R11 B data read", rdB, xb);
    else           check("R12 B absent read", rdB, xb);
    if (a == 3'd0)      check("R2 C data read", {8'h0, rdC}, {8'h0, xc});
    else if (a == 3'd1) check("R5 C set read", {8'h0, rdC}, {8'h0, xc});
    else                check("R12 C absent read", {8'h0, rdC}, {8'h0, xc});
    check("R13 A out after read", outA, eA_out);
    check("R13 A oe after read", oeA, eA_dir);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 A out", outA, 16'h0);
    check("R1 A oe", oeA, 16'h0);
    check("R1 B out", outB, 16'h0);
    check("R1 C out", {8'h0, outC}, 16'h0);
    check("R1 rdata", rdA | rdB, 16'h0);
    check("R8 C oe after reset", {8'h0, oeC}, 16'h00FF);
    for (int a = 0; a < 8; a++) do_read(3'(a));

    // single-bit sweeps of set and clear
    for (int b = 0; b < 16; b++) do_write(3'd1, 16'h1 << b);
    check("R9 A all usable set", outA, MA);
    for (int b = 0; b < 16; b++) do_write(3'd2, 16'h1 << b);
    for (int b = 0; b < 16; b++) do_write(3'd3, 16'h1 << b);
    for (int b = 0; b < 16; b++) do_write(3'd4, ~(16'h1 << b));

    // mixed pattern sweep over every address
    for (int k = 0; k < 96; k++) begin
      logic [15:0] d;
      d = 16'(k * 13711) ^ 16'(k << 9) ^ 16'hA5C3;
      do_write(3'(k % 8), d);
      @(negedge clk);
      pins = d ^ 16'h0FF0 ^ 16'(k * 977);
      repeat (3) @(negedge clk);
      for (int a = 0; a < 8; a++) do_read(3'(a));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule